// File: doc/BRIEF.md
# Instruction-List Accumulator Controller Core

This core runs a ladder-style control program held in an external synchronous program memory. It presents a program counter as the memory address, takes back one 15-bit word, and executes it against an 8-bit accumulator. Each word carries a 5-bit opcode in its top bits and a 10-bit field below it. Operands come from one of four spaces: the discrete input vector, the discrete output vector, an internal bit store, or an internal byte store. An END word sends the counter back to a start address, so the program runs as a repeating scan.

The work of one instruction spans two clock cycles. In the fetch cycle the counter is on the address port while the memory captures the word. In the execute cycle the core decodes the returned word, updates the accumulator, carry, stores and outputs, and then loads the counter. Opcodes that the core does not implement are skipped. This covers multiply, divide, the peripheral opcodes and the all-ones word found in blank memory.

Top module: `plc_core`

## Requirements
- R1: While reset is high at a clock edge, the program address, accumulator, carry flag and every output bit become 0.
- R2: Each instruction takes two cycles. The program address holds through the cycle in which the memory captures the word. The word is then executed in the next cycle, and the address changes only at the end of that cycle.
- R3: END (opcode 00000) loads the program counter with the 10-bit field, unconditionally.
- R4: JMP (opcode 00001) loads the program counter with the field when accumulator bit 0 is 1. Otherwise the counter advances by one.
- R5: The operand field is decoded as follows. Bit 9 is the invert flag, bits 8:7 select the space (00 input, 01 output, 10 bit store, 11 byte store), and bits 6:0 are the address. Ld (00010) copies the operand into the accumulator. A bit operand fills bit 0 and the upper bits are cleared.
- R6: With the invert flag set, a byte operand is complemented in all 8 bits, and a bit operand is complemented as a single bit before use. On a store, the stored value is complemented.
- R7: Ldi (00011) loads field bits 7:0 into the accumulator.
- R8: ST (00100) writes accumulator bit 0 to an output (space 01) or to the bit store (space 10), or writes the whole accumulator to the byte store (space 11). With space 00 it changes nothing.
- R9: ADD (00101) and SUB (00110) form a 9-bit result. The accumulator takes bits 7:0 and the carry flag takes bit 8. No other instruction changes the carry flag.
- R10: AND (01001), OR (01010) and XOR (01011) combine the accumulator bitwise with the operand.
- R11: GT (01100), GE (01101), EQ (01110), LE (01111) and LT (10000) compare the accumulator with the operand, as unsigned values with the accumulator on the left. They leave 1 in the accumulator if the relation holds and 0 if it does not.
- R12: Any other opcode, including 11111, 00111, 01000 and 10001 to 11110, changes no state except that the counter advances by one.
- R13: An input or output address at or beyond the vector width reads as 0, and a store to such an output address is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pgmAddr | output | 10 | Program memory address (program counter) |
| pgmData | input | 15 | Word returned by the memory one cycle after the address |
| inBits | input | 16 | Discrete input vector |
| outBits | output | 16 | Discrete output vector |
| accValue | output | 8 | Accumulator contents |
| carryFlag | output | 1 | Carry from the last ADD or SUB |

## Verification
Two functions of this block can act in the same execute cycle: the accumulator update that decides a conditional jump, and the jump itself. The bench sets accumulator bit 0 with Ldi and then issues JMP over two filler words. It then clears bit 0 and issues a backward JMP. The address after each execute cycle must show the jump taken in the first case and a plain increment in the second. Carry retention is exercised the same way: a logic operation directly follows an ADD that set the carry, and the carry must survive it.

// File: rtl/plc_pkg.sv
package plc_pkg;

  localparam int OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_END = 5'b00000,
    OP_JMP = 5'b00001,
    OP_LD  = 5'b00010,
    OP_LDI = 5'b00011,
    OP_ST  = 5'b00100,
    OP_ADD = 5'b00101,
    OP_SUB = 5'b00110,
    OP_AND = 5'b01001,
    OP_OR  = 5'b01010,
    OP_XOR = 5'b01011,
    OP_GT  = 5'b01100,
    OP_GE  = 5'b01101,
    OP_EQ  = 5'b01110,
    OP_LE  = 5'b01111,
    OP_LT  = 5'b10000
  } opcode_e;

  typedef enum logic [1:0] {
    SP_IN   = 2'b00,
    SP_OUT  = 2'b01,
    SP_BIT  = 2'b10,
    SP_BYTE = 2'b11
  } space_e;

  typedef enum logic [3:0] {
    ALU_PASS, ALU_IMM, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_GT, ALU_GE, ALU_EQ, ALU_LE, ALU_LT
  } aluOp_e;

  // Strobes from control to datapath, valid only in the execute cycle.
  typedef struct packed {
    logic   accWr;
    logic   wrCarry;
    logic   storeEn;
    logic   negate;
    space_e space;
    aluOp_e aluOp;
  } strobe_t;

endpackage

// File: rtl/plc_control.sv
module plc_control
  import plc_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int INST_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INST_W-1:0] instWord,
  input  logic              accBit0,
  output logic [PC_W-1:0]   pc,
  output strobe_t           stb
);
  localparam int FIELD_W = INST_W - OPC_W;

  typedef enum logic {S_FETCH, S_EXEC} state_e;
  state_e state;

  logic [OPC_W-1:0]   opc;
  logic [FIELD_W-1:0] field;
  logic               execNow;

  assign opc     = instWord[INST_W-1 -: OPC_W];
  assign field   = instWord[FIELD_W-1:0];
  assign execNow = (state == S_EXEC);

  always_comb begin
    stb        = '0;
    stb.negate = field[FIELD_W-1];
    stb.space  = space_e'(field[FIELD_W-2 -: 2]);
    stb.aluOp  = ALU_PASS;
    if (execNow) begin
      case (opc)
        OP_LD:  begin stb.accWr = 1'b1; stb.aluOp = ALU_PASS; end
        OP_LDI: begin stb.accWr = 1'b1; stb.aluOp = ALU_IMM;  end
        OP_ST:  stb.storeEn = 1'b1;
        OP_ADD: begin stb.accWr = 1'b1; stb.wrCarry = 1'b1; stb.aluOp = ALU_ADD; end
        OP_SUB: begin stb.accWr = 1'b1; stb.wrCarry = 1'b1; stb.aluOp = ALU_SUB; end
        OP_AND: begin stb.accWr = 1'b1; stb.aluOp = ALU_AND; end
        OP_OR:  begin stb.accWr = 1'b1; stb.aluOp = ALU_OR;  end
        OP_XOR: begin stb.accWr = 1'b1; stb.aluOp = ALU_XOR; end
        OP_GT:  begin stb.accWr = 1'b1; stb.aluOp = ALU_GT;  end
        OP_GE:  begin stb.accWr = 1'b1; stb.aluOp = ALU_GE;  end
        OP_EQ:  begin stb.accWr = 1'b1; stb.aluOp = ALU_EQ;  end
        OP_LE:  begin stb.accWr = 1'b1; stb.aluOp = ALU_LE;  end
        OP_LT:  begin stb.accWr = 1'b1; stb.aluOp = ALU_LT;  end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      pc    <= '0;
    end else if (state == S_FETCH) begin
      state <= S_EXEC;
    end else begin
      state <= S_FETCH;
      if (opc == OP_END || (opc == OP_JMP && accBit0))
        pc <= PC_W'(field);
      else
        pc <= pc + PC_W'(1);
    end
  end

  assert_pc_hold_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (pc == $past(pc)));

  assert_end_target_R3: assert property (@(posedge clk) disable iff (rst)
    (execNow && opc == OP_END) |=> (pc == PC_W'($past(field))));

  assert_jmp_fallthrough_R4: assert property (@(posedge clk) disable iff (rst)
    (execNow && opc == OP_JMP && !accBit0) |=> (pc == $past(pc) + PC_W'(1)));

endmodule

// File: rtl/plc_datapath.sv
module plc_datapath
  import plc_pkg::*;
#(
  parameter int NUM_IN  = 16,
  parameter int NUM_OUT = 16,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  logic [DATA_W-1:0]  opLow,
  input  logic [NUM_IN-1:0]  inBits,
  output logic [NUM_OUT-1:0] outBits,
  output logic [DATA_W-1:0]  acc,
  output logic               carry
);
  localparam int SPAN = 1 << ADDR_W;

  logic [ADDR_W-1:0] addr;
  logic [SPAN-1:0]   inPad, outPad;
  logic [SPAN-1:0]   bitRam;
  logic [DATA_W-1:0] byteRam [SPAN];
  logic              rawBit;
  logic [DATA_W-1:0] operand;
  logic [DATA_W:0]   sum, diff;
  logic [DATA_W-1:0] accNext;
  logic              carryNext;
  logic              storeBit;
  logic [DATA_W-1:0] storeByte;

  assign addr   = opLow[ADDR_W-1:0];
  assign inPad  = SPAN'(inBits);
  assign outPad = SPAN'(outBits);

  always_comb begin
    case (stb.space)
      SP_IN:   rawBit = inPad[addr];
      SP_OUT:  rawBit = outPad[addr];
      default: rawBit = bitRam[addr];
    endcase
    if (stb.space == SP_BYTE)
      operand = byteRam[addr] ^ {DATA_W{stb.negate}};
    else
      operand = DATA_W'(rawBit ^ stb.negate);
  end

  assign sum  = {1'b0, acc} + {1'b0, operand};
  assign diff = {1'b0, acc} - {1'b0, operand};

  always_comb begin
    accNext   = operand;
    carryNext = carry;
    case (stb.aluOp)
      ALU_IMM: accNext = opLow;
      ALU_ADD: {carryNext, accNext} = sum;
      ALU_SUB: {carryNext, accNext} = diff;
      ALU_AND: accNext = acc & operand;
      ALU_OR:  accNext = acc | operand;
      ALU_XOR: accNext = acc ^ operand;
      ALU_GT:  accNext = DATA_W'(acc >  operand);
      ALU_GE:  accNext = DATA_W'(acc >= operand);
      ALU_EQ:  accNext = DATA_W'(acc == operand);
      ALU_LE:  accNext = DATA_W'(acc <= operand);
      ALU_LT:  accNext = DATA_W'(acc <  operand);
      default: accNext = operand;
    endcase
  end

  assign storeBit  = acc[0] ^ stb.negate;
  assign storeByte = acc ^ {DATA_W{stb.negate}};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      carry <= 1'b0;
    end else begin
      if (stb.accWr)   acc   <= accNext;
      if (stb.wrCarry) carry <= carryNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitRam <= '0;
      for (int i = 0; i < SPAN; i++) byteRam[i] <= '0;
    end else if (stb.storeEn) begin
      if (stb.space == SP_BIT)  bitRam[addr]  <= storeBit;
      if (stb.space == SP_BYTE) byteRam[addr] <= storeByte;
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst)
        outBits[g] <= 1'b0;
      else if (stb.storeEn && stb.space == SP_OUT && addr == ADDR_W'(g))
        outBits[g] <= storeBit;
    end
  end

  assert_carry_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !stb.wrCarry |=> $stable(carry));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(stb.storeEn && stb.space == SP_OUT) |=> $stable(outBits));

  assert_acc_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !stb.accWr |=> $stable(acc));

  assert_cmp_boolean_R11: assert property (@(posedge clk) disable iff (rst)
    (stb.accWr && stb.aluOp inside {ALU_GT, ALU_GE, ALU_EQ, ALU_LE, ALU_LT})
      |=> (acc[DATA_W-1:1] == '0));

endmodule

// File: rtl/plc_core.sv
module plc_core
  import plc_pkg::*;
#(
  parameter int PC_W    = 10,
  parameter int INST_W  = 15,
  parameter int NUM_IN  = 16,
  parameter int NUM_OUT = 16,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    pgmAddr,
  input  logic [INST_W-1:0]  pgmData,
  input  logic [NUM_IN-1:0]  inBits,
  output logic [NUM_OUT-1:0] outBits,
  output logic [DATA_W-1:0]  accValue,
  output logic               carryFlag
);
  strobe_t stb;

  plc_control #(.PC_W(PC_W), .INST_W(INST_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .instWord (pgmData),
    .accBit0  (accValue[0]),
    .pc       (pgmAddr),
    .stb      (stb)
  );

  plc_datapath #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .opLow   (pgmData[DATA_W-1:0]),
    .inBits  (inBits),
    .outBits (outBits),
    .acc     (accValue),
    .carry   (carryFlag)
  );

endmodule

// File: tb/plc_core_bench.sv
module plc_core_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  pgmAddr;
  logic [14:0] pgmData;
  logic [15:0] inBits;
  logic [15:0] outBits;
  logic [7:0]  accValue;
  logic        carryFlag;

  always #5 clk = ~clk;

  plc_core u_plc_core (
    .clk(clk), .rst(rst), .pgmAddr(pgmAddr), .pgmData(pgmData),
    .inBits(inBits), .outBits(outBits), .accValue(accValue), .carryFlag(carryFlag)
  );

  // Synchronous program memory model: one cycle of read latency.
  logic [14:0] rom [1024];
  always @(posedge clk) pgmData <= rom[pgmAddr];

  localparam logic [4:0] END = 5'b00000, JMP = 5'b00001, LD = 5'b00010, LDI = 5'b00011,
    ST = 5'b00100, ADD = 5'b00101, SUB = 5'b00110, AND = 5'b01001, OR = 5'b01010,
    XOR = 5'b01011, GT = 5'b01100, GE = 5'b01101, EQ = 5'b01110, LE = 5'b01111, LT = 5'b10000;
  localparam logic [9:0] B5 = {1'b0, 2'b11, 7'd5}, NB5 = {1'b1, 2'b11, 7'd5};
  localparam logic [9:0] O3 = {1'b0, 2'b01, 7'd3}, NO4 = {1'b1, 2'b01, 7'd4};
  localparam logic [9:0] O20 = {1'b0, 2'b01, 7'd20};
  localparam logic [9:0] I0 = {1'b0, 2'b00, 7'd0}, NI0 = {1'b1, 2'b00, 7'd0};
  localparam logic [9:0] I2 = {1'b0, 2'b00, 7'd2}, I3 = {1'b0, 2'b00, 7'd3};
  localparam logic [9:0] I6 = {1'b0, 2'b00, 7'd6}, I20 = {1'b0, 2'b00, 7'd20};
  localparam logic [9:0] R100 = {1'b0, 2'b10, 7'd100}, NR100 = {1'b1, 2'b10, 7'd100};

  typedef struct packed {
    logic [9:0]  addr;
    logic [14:0] word;
    logic [7:0]  acc;
    logic        carry;
    logic [15:0] outs;
    logic [9:0]  npc;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VEC [NV] = '{
    '{10'd0,  {LDI, 10'h03C}, 8'h3C, 1'b0, 16'h0000, 10'd1},   // R7
    '{10'd1,  {ST, B5},       8'h3C, 1'b0, 16'h0000, 10'd2},   // R8 byte store
    '{10'd2,  {LDI, 10'h0F0}, 8'hF0, 1'b0, 16'h0000, 10'd3},
    '{10'd3,  {ADD, B5},      8'h2C, 1'b1, 16'h0000, 10'd4},   // R9 carry out
    '{10'd4,  {SUB, B5},      8'hF0, 1'b1, 16'h0000, 10'd5},   // R9 borrow
    '{10'd5,  {SUB, B5},      8'hB4, 1'b0, 16'h0000, 10'd6},   // R9
    '{10'd6,  {AND, NB5},     8'h80, 1'b0, 16'h0000, 10'd7},   // R6 R10
    '{10'd7,  {OR, B5},       8'hBC, 1'b0, 16'h0000, 10'd8},   // R10
    '{10'd8,  {XOR, B5},      8'h80, 1'b0, 16'h0000, 10'd9},   // R10
    '{10'd9,  {GT, B5},       8'h01, 1'b0, 16'h0000, 10'd10},  // R11
    '{10'd10, {ST, O3},       8'h01, 1'b0, 16'h0008, 10'd11},  // R8 output
    '{10'd11, {LDI, 10'h000}, 8'h00, 1'b0, 16'h0008, 10'd12},
    '{10'd12, {ST, NO4},      8'h00, 1'b0, 16'h0018, 10'd13},  // R6 inverted store
    '{10'd13, {LD, I0},       8'h01, 1'b0, 16'h0018, 10'd14},  // R5
    '{10'd14, {LD, NI0},      8'h00, 1'b0, 16'h0018, 10'd15},  // R6 bit
    '{10'd15, {LD, I6},       8'h01, 1'b0, 16'h0018, 10'd16},  // R5
    '{10'd16, {LD, I2},       8'h00, 1'b0, 16'h0018, 10'd17},  // R5
    '{10'd17, {LD, O3},       8'h01, 1'b0, 16'h0018, 10'd18},  // R5 output space
    '{10'd18, {ST, R100},     8'h01, 1'b0, 16'h0018, 10'd19},  // R8 bit store
    '{10'd19, {LDI, 10'h000}, 8'h00, 1'b0, 16'h0018, 10'd20},
    '{10'd20, {LD, R100},     8'h01, 1'b0, 16'h0018, 10'd21},  // R5 bit store
    '{10'd21, {LD, NR100},    8'h00, 1'b0, 16'h0018, 10'd22},  // R6
    '{10'd22, {ST, I3},       8'h00, 1'b0, 16'h0018, 10'd23},  // R8 space 00 no effect
    '{10'd23, {LD, B5},       8'h3C, 1'b0, 16'h0018, 10'd24},  // R5 byte
    '{10'd24, {EQ, B5},       8'h01, 1'b0, 16'h0018, 10'd25},  // R11
    '{10'd25, {LDI, 10'h03C}, 8'h3C, 1'b0, 16'h0018, 10'd26},
    '{10'd26, {LT, B5},       8'h00, 1'b0, 16'h0018, 10'd27},  // R11
    '{10'd27, {LDI, 10'h03C}, 8'h3C, 1'b0, 16'h0018, 10'd28},
    '{10'd28, {LE, B5},       8'h01, 1'b0, 16'h0018, 10'd29},  // R11
    '{10'd29, {LDI, 10'h03B}, 8'h3B, 1'b0, 16'h0018, 10'd30},
    '{10'd30, {GE, B5},       8'h00, 1'b0, 16'h0018, 10'd31},  // R11
    '{10'd31, 15'h7FFF,       8'h00, 1'b0, 16'h0018, 10'd32},  // R12 blank word
    '{10'd32, {5'b00111, 10'h3FF}, 8'h00, 1'b0, 16'h0018, 10'd33}, // R12
    '{10'd33, {5'b10110, 10'h000}, 8'h00, 1'b0, 16'h0018, 10'd34}, // R12
    '{10'd34, {LDI, 10'h001}, 8'h01, 1'b0, 16'h0018, 10'd35},
    '{10'd35, {JMP, 10'd38},  8'h01, 1'b0, 16'h0018, 10'd38},  // R4 taken
    '{10'd38, {LDI, 10'h002}, 8'h02, 1'b0, 16'h0018, 10'd39},
    '{10'd39, {JMP, 10'd36},  8'h02, 1'b0, 16'h0018, 10'd40},  // R4 not taken
    '{10'd40, {LD, I20},      8'h00, 1'b0, 16'h0018, 10'd41},  // R13 read
    '{10'd41, {LDI, 10'h001}, 8'h01, 1'b0, 16'h0018, 10'd42},
    '{10'd42, {ST, O20},      8'h01, 1'b0, 16'h0018, 10'd43},  // R13 write dropped
    '{10'd43, {END, 10'd50},  8'h01, 1'b0, 16'h0018, 10'd50},  // R3
    '{10'd50, {LDI, 10'h0FF}, 8'hFF, 1'b0, 16'h0018, 10'd51},
    '{10'd51, {ADD, B5},      8'h3B, 1'b1, 16'h0018, 10'd52},  // R9
    '{10'd52, {XOR, B5},      8'h07, 1'b1, 16'h0018, 10'd53},  // R9 carry kept
    '{10'd53, {END, 10'd0},   8'h07, 1'b1, 16'h0018, 10'd0}    // R3
  };

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) rom[a] = 15'h7FFF;
    for (int i = 0; i < NV; i++) rom[VEC[i].addr] = VEC[i].word;
    rom[36] = {LDI, 10'h0FF};
    rom[37] = {LDI, 10'h0FF};
    rst    = 1'b1;
    inBits = 16'hA5C3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pgmAddr", 32'(pgmAddr), 32'd0);
    chk("R1 reset acc", 32'(accValue), 32'd0);
    chk("R1 reset carry", 32'(carryFlag), 32'd0);
    chk("R1 reset outBits", 32'(outBits), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk($sformatf("step %0d acc", i), 32'(accValue), 32'(VEC[i].acc));
      chk($sformatf("step %0d carry", i), 32'(carryFlag), 32'(VEC[i].carry));
      chk($sformatf("step %0d outBits", i), 32'(outBits), 32'(VEC[i].outs));
      chk($sformatf("step %0d pgmAddr", i), 32'(pgmAddr), 32'(VEC[i].npc));
    end

    // R2: address holds through the fetch cycle, moves after the execute cycle.
    @(posedge clk); @(negedge clk);
    chk("R2 address held during fetch", 32'(pgmAddr), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R2 address advanced after execute", 32'(pgmAddr), 32'd1);
    chk("R2 word executed in second cycle", 32'(accValue), 32'h3C);

    // R1: reset in the middle of a run.
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 mid-run pgmAddr", 32'(pgmAddr), 32'd0);
    chk("R1 mid-run acc", 32'(accValue), 32'd0);
    chk("R1 mid-run carry", 32'(carryFlag), 32'd0);
    chk("R1 mid-run outBits", 32'(outBits), 32'd0);
    rst = 1'b0;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule